// File: doc/BRIEF.md
# Current-Limit Chopping Timer

This block keeps the load current of a full-bridge motor driver under a regulation ceiling by chopping it. An external comparator raises a single-bit flag once the sensed current reaches the ceiling. When the flag is sampled with the bridge running, the block forces the output stage to high impedance for a fixed off-time. The load current then decays through the free-wheel path. After the off-time the stage is switched back on, and a blanking window follows in which the comparator is not looked at. This keeps switching transients from retriggering the chop. At the end of the window the block is armed again.

Chopping is not a fault. The block reports it on an active-low limitation indicator and raises no fault. That indicator stays low from the first off-time until one full quiet window has passed with the bridge armed and no new threshold hit. A second active-low indicator mirrors a thermal-reduction request, one register stage later. Short-circuit handling and analog sensing belong to other blocks. All durations are parameters counted in clock cycles.

Top module: `chop_timer`

## Requirements
- R1: During and right after reset, `stageHiZ` is 1, `limitFlagN` is 1 and `reducedFlagN` is 1.
- R2: When `bridgeEn` is sampled low, `stageHiZ` is 1 and `limitFlagN` is 1 from the next cycle on, even in the middle of a chop. Once `bridgeEn` is sampled high again, `stageHiZ` becomes 0 one cycle later and `limitFlagN` stays 1.
- R3: When `overThresh` is sampled high while the bridge is armed, `stageHiZ` is 1 and `limitFlagN` is 0 (0 means limitation active) in the next cycle.
- R4: The forced high-impedance phase lasts exactly OFF_CYCLES cycles. Holding `overThresh` high during it does not lengthen it.
- R5: The off-time is followed by exactly BLANK_CYCLES cycles with the stage on (`stageHiZ` 0). During these cycles `overThresh` is ignored, and a pulse is neither acted on nor remembered once the block re-arms.
- R6: With `overThresh` held high, `stageHiZ` repeats with a period of OFF_CYCLES+BLANK_CYCLES+1 cycles: 1 for OFF_CYCLES cycles, then 0 for the remainder.
- R7: After a chop, `limitFlagN` returns to 1 only after QUIET_CYCLES consecutive armed cycles without a threshold hit. A hit inside that window keeps it at 0.
- R8: A threshold hit in the same cycle that would complete the quiet window starts a new off-time and keeps `limitFlagN` at 0.
- R9: `reducedFlagN` equals the inverse of `thermReduce` as sampled one cycle earlier, whatever the chopping state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bridgeEn | input | 1 | Request to run the bridge |
| overThresh | input | 1 | Comparator flag: load current at the regulation ceiling |
| thermReduce | input | 1 | Temperature-dependent reduced ceiling is in force |
| stageHiZ | output | 1 | 1 forces all output transistors off |
| limitFlagN | output | 1 | 0 while current limitation is active |
| reducedFlagN | output | 1 | 0 while the reduced ceiling is in force |

## Verification
The coincidence that matters is a threshold hit landing on the same edge at which the quiet window would clear the limitation indicator. In that case the new hit must win: the stage goes to high impedance and the indicator stays low. The bench sweeps the hit position across every cycle of the quiet window in a small configuration, including its final cycle. It judges each position by the output levels one cycle after the hit. A second overlap is a threshold pulse during blanking. The bench places such a pulse in every blanking cycle and then checks that no off-time follows once the block is armed again.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_OFF   = 2'd2,
    ST_BLANK = 2'd3
  } chopState_t;

  // strobes from control to the phase counter
  typedef struct packed {
    logic clr;
    logic inc;
  } cntStrobe_t;

endpackage

// File: rtl/chop_timer_dp.sv
module chop_timer_dp
  import chop_pkg::*;
#(
  parameter int OFF_CYCLES   = 850,
  parameter int BLANK_CYCLES = 575,
  parameter int QUIET_CYCLES = 1425
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cntStrobe_t strobe,
  input  logic       thermReduce,
  output logic       offDone,
  output logic       blankDone,
  output logic       quietDone,
  output logic       reducedQ
);

  localparam int MAX_AB = (OFF_CYCLES > BLANK_CYCLES) ? OFF_CYCLES : BLANK_CYCLES;
  localparam int MAXC   = (MAX_AB > QUIET_CYCLES) ? MAX_AB : QUIET_CYCLES;
  localparam int CNT_W  = (MAXC > 1) ? $clog2(MAXC + 1) : 1;
  localparam int NPH    = 3;

  localparam int TERM [NPH] = '{OFF_CYCLES - 1, BLANK_CYCLES - 1, QUIET_CYCLES - 1};

  logic [CNT_W-1:0] phaseCnt;
  logic [NPH-1:0]   termHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
    end else if (strobe.clr) begin
      phaseCnt <= '0;
    end else if (strobe.inc) begin
      phaseCnt <= phaseCnt + CNT_W'(1);
    end
  end

  // one terminal-count comparator per timed phase
  for (genvar g = 0; g < NPH; g++) begin : g_term
    assign termHit[g] = (phaseCnt == CNT_W'(TERM[g]));
  end

  assign offDone   = termHit[0];
  assign blankDone = termHit[1];
  assign quietDone = termHit[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reducedQ <= 1'b0;
    end else begin
      reducedQ <= thermReduce;
    end
  end

endmodule

// File: rtl/chop_timer_ctl.sv
module chop_timer_ctl
  import chop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bridgeEn,
  input  logic       overThresh,
  input  logic       offDone,
  input  logic       blankDone,
  input  logic       quietDone,
  output chopState_t ctlState,
  output cntStrobe_t strobe,
  output logic       limActive
);

  chopState_t stateNext;
  logic       limNext;

  always_comb begin
    stateNext  = ctlState;
    limNext    = limActive;
    strobe.clr = 1'b0;
    strobe.inc = 1'b0;
    if (!bridgeEn) begin
      stateNext  = ST_IDLE;
      limNext    = 1'b0;
      strobe.clr = 1'b1;
    end else begin
      unique case (ctlState)
        ST_IDLE: begin
          stateNext  = ST_ARMED;
          limNext    = 1'b0;
          strobe.clr = 1'b1;
        end
        ST_ARMED: begin
          if (overThresh) begin
            // a new hit outranks a quiet window that ends now
            stateNext  = ST_OFF;
            limNext    = 1'b1;
            strobe.clr = 1'b1;
          end else if (limActive) begin
            if (quietDone) begin
              limNext    = 1'b0;
              strobe.clr = 1'b1;
            end else begin
              strobe.inc = 1'b1;
            end
          end
        end
        ST_OFF: begin
          if (offDone) begin
            stateNext  = ST_BLANK;
            strobe.clr = 1'b1;
          end else begin
            strobe.inc = 1'b1;
          end
        end
        ST_BLANK: begin
          // comparator deliberately not consulted here
          if (blankDone) begin
            stateNext  = ST_ARMED;
            strobe.clr = 1'b1;
          end else begin
            strobe.inc = 1'b1;
          end
        end
        default: begin
          stateNext  = ST_IDLE;
          strobe.clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctlState  <= ST_IDLE;
      limActive <= 1'b0;
    end else begin
      ctlState  <= stateNext;
      limActive <= limNext;
    end
  end

endmodule

// File: rtl/chop_timer.sv
module chop_timer
  import chop_pkg::*;
#(
  parameter int OFF_CYCLES   = 850,
  parameter int BLANK_CYCLES = 575,
  parameter int QUIET_CYCLES = OFF_CYCLES + BLANK_CYCLES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bridgeEn,
  input  logic overThresh,
  input  logic thermReduce,
  output logic stageHiZ,
  output logic limitFlagN,
  output logic reducedFlagN
);

  chopState_t ctlState;
  cntStrobe_t strobe;
  logic       offDone;
  logic       blankDone;
  logic       quietDone;
  logic       limActive;
  logic       reducedQ;

  chop_timer_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bridgeEn   (bridgeEn),
    .overThresh (overThresh),
    .offDone    (offDone),
    .blankDone  (blankDone),
    .quietDone  (quietDone),
    .ctlState   (ctlState),
    .strobe     (strobe),
    .limActive  (limActive)
  );

  chop_timer_dp #(
    .OFF_CYCLES   (OFF_CYCLES),
    .BLANK_CYCLES (BLANK_CYCLES),
    .QUIET_CYCLES (QUIET_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .thermReduce (thermReduce),
    .offDone     (offDone),
    .blankDone   (blankDone),
    .quietDone   (quietDone),
    .reducedQ    (reducedQ)
  );

  assign stageHiZ     = (ctlState == ST_IDLE) || (ctlState == ST_OFF);
  assign limitFlagN   = ~limActive;
  assign reducedFlagN = ~reducedQ;

endmodule

// File: rtl/chop_timer_chk.sv
module chop_timer_chk
  import chop_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bridgeEn,
  input logic       overThresh,
  input logic       thermReduce,
  input logic       stageHiZ,
  input logic       limitFlagN,
  input logic       reducedFlagN,
  input chopState_t ctlState,
  input logic       offDone,
  input logic       blankDone,
  input logic       quietDone
);

  p_disable_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bridgeEn |=> (stageHiZ && limitFlagN));

  p_hit_chops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bridgeEn && ctlState == ST_ARMED && overThresh) |=> (ctlState == ST_OFF && !limitFlagN));

  p_off_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bridgeEn && ctlState == ST_OFF && !offDone) |=> (ctlState == ST_OFF && stageHiZ));

  p_blank_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bridgeEn && ctlState == ST_BLANK && !blankDone) |=> (ctlState == ST_BLANK && !stageHiZ));

  p_quiet_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bridgeEn && ctlState == ST_ARMED && !overThresh && !quietDone && !limitFlagN) |=> !limitFlagN);

  p_reduced_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    thermReduce |=> !reducedFlagN);

endmodule

bind chop_timer chop_timer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bridgeEn     (bridgeEn),
  .overThresh   (overThresh),
  .thermReduce  (thermReduce),
  .stageHiZ     (stageHiZ),
  .limitFlagN   (limitFlagN),
  .reducedFlagN (reducedFlagN),
  .ctlState     (ctlState),
  .offDone      (offDone),
  .blankDone    (blankDone),
  .quietDone    (quietDone)
);

// File: tb/test_chop_timer.sv
module test_chop_timer;

  localparam int OFF   = 4;
  localparam int BLANK = 3;
  localparam int QUIET = 7;
  localparam int P     = OFF + BLANK + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic bridgeEn;
  logic overThresh;
  logic thermReduce;
  logic stageHiZ;
  logic limitFlagN;
  logic reducedFlagN;

  int total  = 0;
  int failed = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  chop_timer #(
    .OFF_CYCLES   (OFF),
    .BLANK_CYCLES (BLANK),
    .QUIET_CYCLES (QUIET)
  ) i_chop_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .bridgeEn     (bridgeEn),
    .overThresh   (overThresh),
    .thermReduce  (thermReduce),
    .stageHiZ     (stageHiZ),
    .limitFlagN   (limitFlagN),
    .reducedFlagN (reducedFlagN)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // leaves one cycle after the hit edge (n = 0)
  task automatic startChop();
    bridgeEn = 1'b0;
    tick();
    bridgeEn = 1'b1;
    tick();
    overThresh = 1'b1;
    tick();
    overThresh = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", total, failed);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bridgeEn = 1'b0; overThresh = 1'b0; thermReduce = 1'b0;
    repeat (3) tick();
    chk("R1", "stageHiZ in reset", stageHiZ, 1'b1);
    chk("R1", "limitFlagN in reset", limitFlagN, 1'b1);
    chk("R1", "reducedFlagN in reset", reducedFlagN, 1'b1);
    rst_n = 1'b1;
    tick();
    chk("R1", "stageHiZ after reset", stageHiZ, 1'b1);

    // R2: enable
    bridgeEn = 1'b1;
    tick();
    chk("R2", "stageHiZ after enable", stageHiZ, 1'b0);
    chk("R2", "limitFlagN after enable", limitFlagN, 1'b1);

    // R3 and R4: hit, threshold held through off-time
    startChop();
    chk("R3", "stageHiZ after hit", stageHiZ, 1'b1);
    chk("R3", "limitFlagN after hit", limitFlagN, 1'b0);
    for (int k = 1; k <= OFF + BLANK; k++) begin
      overThresh = (k < OFF);
      tick();
      chk("R4", $sformatf("stageHiZ n=%0d", k), stageHiZ, (k < OFF));
    end
    overThresh = 1'b0;

    // R5: pulse in each blanking cycle, none remembered
    for (int j = 0; j < BLANK; j++) begin
      startChop();
      repeat (OFF + j) tick();
      overThresh = 1'b1;
      tick();
      overThresh = 1'b0;
      chk("R5", $sformatf("stageHiZ blank pulse j=%0d", j), stageHiZ, 1'b0);
      repeat (BLANK - j) tick();
      chk("R5", $sformatf("no queued chop j=%0d", j), stageHiZ, 1'b0);
    end

    // R6: continuous threshold
    bridgeEn = 1'b0;
    tick();
    bridgeEn = 1'b1;
    tick();
    overThresh = 1'b1;
    tick();
    for (int n = 1; n <= 3 * P; n++) begin
      tick();
      chk("R6", $sformatf("stageHiZ period n=%0d", n), stageHiZ, ((n % P) < OFF));
      chk("R6", $sformatf("limitFlagN period n=%0d", n), limitFlagN, 1'b0);
    end
    overThresh = 1'b0;

    // R7: quiet window clears the indicator
    startChop();
    for (int k = 1; k <= OFF + BLANK + QUIET; k++) begin
      tick();
      chk("R7", $sformatf("limitFlagN quiet k=%0d", k), limitFlagN, (k >= OFF + BLANK + QUIET));
    end

    // R7 hits inside the window, R8 hit on its last cycle
    for (int m = 1; m <= QUIET; m++) begin
      startChop();
      repeat (OFF + BLANK + m - 1) tick();
      overThresh = 1'b1;
      tick();
      overThresh = 1'b0;
      chk((m == QUIET) ? "R8" : "R7", $sformatf("stageHiZ rehit m=%0d", m), stageHiZ, 1'b1);
      chk((m == QUIET) ? "R8" : "R7", $sformatf("limitFlagN rehit m=%0d", m), limitFlagN, 1'b0);
    end

    // R2: disable in the middle of a chop
    startChop();
    tick();
    bridgeEn = 1'b0;
    tick();
    chk("R2", "stageHiZ disabled mid-chop", stageHiZ, 1'b1);
    chk("R2", "limitFlagN disabled mid-chop", limitFlagN, 1'b1);
    bridgeEn = 1'b1;
    tick();
    chk("R2", "stageHiZ re-enabled", stageHiZ, 1'b0);
    chk("R2", "limitFlagN re-enabled", limitFlagN, 1'b1);

    // R9: reduced indicator, idle and while chopping
    bridgeEn = 1'b0;
    thermReduce = 1'b1;
    tick();
    chk("R9", "reducedFlagN idle", reducedFlagN, 1'b0);
    startChop();
    chk("R9", "reducedFlagN chopping", reducedFlagN, 1'b0);
    thermReduce = 1'b0;
    tick();
    chk("R9", "reducedFlagN released", reducedFlagN, 1'b1);
    chk("R9", "stageHiZ unaffected", stageHiZ, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

endmodule